// File: doc/BRIEF.md
# Standby Bias Switch Event Manager

This block decides when an auxiliary bias switch may feed the supply rail of a downstream power-factor stage. It takes single-bit, already-synchronised flags from the analog front end: feedback under the skip level, feedback over the standby-exit level, startup judged normal, a confirmed overload fault and a latched shutdown. From these flags it drives the switch enable and a standby indication.

Light load has to persist before the switch opens. The block counts a 1 ms tick while the feedback stays under the skip level and no higher exit level is seen. Only when the count fills a programmable window (125 ticks by default) does the switch open and the standby bit rise. In the other direction, the switch closes on the first clock after the feedback rises over the exit level.

Startup, a confirmed fault and a latched shutdown all force the switch open. Skip-comparator ripple during standby has no effect on the switch.

Top module: `sbias_mgr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bias_en` and `standby` are 0 after that edge, and the block is in its startup phase.
- R2: In the startup phase `bias_en` stays 0 until `start_ok` is 1 at an edge. After that edge `bias_en` is 1.
- R3: With the switch closed, a tick counts only when `tick_ms`=1, `fb_below_skip`=1 and `fb_above_exit`=0 all hold in the same cycle. On the edge of the `WIN_TICKS`-th consecutive counted tick, `bias_en` becomes 0 and `standby` becomes 1.
- R4: A cycle with the switch closed and `fb_below_skip`=0 or `fb_above_exit`=1 clears the tick count to zero, so the full window must elapse again.
- R5: In standby, `fb_above_exit`=1 at an edge makes `bias_en`=1 and `standby`=0 after that edge, whether or not a tick is present.
- R6: In standby, toggling `fb_below_skip` while `fb_above_exit` stays 0 leaves `standby`=1 and `bias_en`=0.
- R7: `fault_cfm`=1 at an edge makes `bias_en` and `standby` 0 after that edge, from any state other than latched. The first edge with `fault_cfm`=0 returns the block to the startup phase, where R2 applies. `start_ok` has no effect while the fault is held.
- R8: `latch_off`=1 at an edge forces `bias_en`=0 and `standby`=0 until the next reset. Every other input is ignored.
- R9: Priority is latch, then fault, then exit and confirmation. `fb_above_exit`=1 in the cycle of what would be the final tick keeps the switch closed and clears the count.
- R10: `bias_en` and `standby` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| fb_below_skip | input | 1 | Feedback under the skip level |
| fb_above_exit | input | 1 | Feedback over the standby-exit level |
| start_ok | input | 1 | Startup judged normal |
| fault_cfm | input | 1 | Confirmed overload fault |
| latch_off | input | 1 | Latched shutdown request |
| bias_en | output | 1 | Bias switch enable |
| standby | output | 1 | Controller is in standby |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is standby exit and a confirmed fault. The bench holds the block in standby, then raises `fb_above_exit` and `fault_cfm` in one cycle. It expects the switch to stay open and `standby` to drop, because the fault wins.

The second pair is window expiry and load recovery. The bench counts ticks to one short of the window, then places `fb_above_exit` on the final tick. It expects the switch to stay closed, and it expects a fresh full window to be needed before standby is entered.

// File: rtl/sbias_pkg.sv
package sbias_pkg;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_RUN   = 3'd1,
    ST_STBY  = 3'd2,
    ST_FAULT = 3'd3,
    ST_LOCK  = 3'd4
  } sbias_state_t;

  // counter width able to hold values 0..win-1
  function automatic int unsigned cnt_width(input int unsigned win);
    return (win < 2) ? 1 : $clog2(win);
  endfunction

  // true when the count already holds win-1 ticks
  function automatic logic window_full(input int unsigned cnt, input int unsigned win);
    return (cnt + 1) >= win;
  endfunction

  // a tick counts only on light load without an exit request
  function automatic logic light_load(input logic below_skip, input logic above_exit);
    return below_skip & ~above_exit;
  endfunction

endpackage

// File: rtl/sbias_lite_timer.sv
module sbias_lite_timer
  import sbias_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic count_en,
  output logic expire
);

  localparam int unsigned CW = cnt_width(WIN_TICKS);

  logic [CW-1:0] cnt_q;

  assign expire = count_en & tick & window_full(int'(cnt_q), WIN_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!count_en) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (expire) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sbias_fsm.sv
module sbias_fsm
  import sbias_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_ok,
  input  logic         exit_req,
  input  logic         fault,
  input  logic         lock_req,
  input  logic         expire,
  output sbias_state_t state
);

  sbias_state_t state_d;

  always_comb begin
    state_d = state;
    if (lock_req || state == ST_LOCK) begin
      state_d = ST_LOCK;
    end else if (fault) begin
      state_d = ST_FAULT;
    end else begin
      unique case (state)
        ST_BOOT:  if (start_ok) state_d = ST_RUN;
        ST_RUN:   if (expire)   state_d = ST_STBY;
        ST_STBY:  if (exit_req) state_d = ST_RUN;
        ST_FAULT: state_d = ST_BOOT;
        default:  state_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_BOOT;
    else        state <= state_d;
  end

endmodule

// File: rtl/sbias_mgr.sv
module sbias_mgr
  import sbias_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic fb_below_skip,
  input  logic fb_above_exit,
  input  logic start_ok,
  input  logic fault_cfm,
  input  logic latch_off,
  output logic bias_en,
  output logic standby
);

  sbias_state_t state;
  logic         light;
  logic         count_en;
  logic         win_expire;

  assign light    = light_load(fb_below_skip, fb_above_exit);
  assign count_en = (state == ST_RUN) & light;

  sbias_lite_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_ms),
    .count_en (count_en),
    .expire   (win_expire)
  );

  sbias_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .exit_req (fb_above_exit),
    .fault    (fault_cfm),
    .lock_req (latch_off),
    .expire   (win_expire),
    .state    (state)
  );

  assign bias_en = (state == ST_RUN);
  assign standby = (state == ST_STBY);

endmodule

// File: rtl/sbias_mgr_chk.sv
module sbias_mgr_chk (
  input logic clk,
  input logic rst_n,
  input logic fb_above_exit,
  input logic start_ok,
  input logic fault_cfm,
  input logic latch_off,
  input logic expire,
  input logic bias_en,
  input logic standby
);

  // R1
  a_r1_reset_off: assert property (@(posedge clk)
    !rst_n |=> (!bias_en && !standby));

  // R2 / R5: the switch only closes after start_ok or an exit request
  a_r2_close_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> ($past(start_ok) || $past(fb_above_exit)));

  // R3
  a_r3_entry_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(expire));

  // R5
  a_r5_exit_now: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && fb_above_exit && !fault_cfm && !latch_off) |=> bias_en);

  // R6
  a_r6_ripple_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !fb_above_exit && !fault_cfm && !latch_off) |=> standby);

  // R7
  a_r7_fault_opens: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cfm |=> (!bias_en && !standby));

  // R8
  a_r8_latch_opens: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off |=> (!bias_en && !standby));

  // R8: once latched, the switch stays open
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch_off) && !bias_en) |=> !bias_en);

  // R10
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_en && standby));

endmodule

bind sbias_mgr sbias_mgr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fb_above_exit (fb_above_exit),
  .start_ok      (start_ok),
  .fault_cfm     (fault_cfm),
  .latch_off     (latch_off),
  .expire        (win_expire),
  .bias_en       (bias_en),
  .standby       (standby)
);

// File: tb/tb_sbias_mgr.sv
`timescale 1ns/1ps
module tb_sbias_mgr;

  localparam int WIN = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, fb_below_skip = 1'b0, fb_above_exit = 1'b0;
  logic start_ok = 1'b0, fault_cfm = 1'b0, latch_off = 1'b0;
  logic bias_en, standby;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbias_mgr #(.WIN_TICKS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .fb_below_skip(fb_below_skip), .fb_above_exit(fb_above_exit),
    .start_ok(start_ok), .fault_cfm(fault_cfm), .latch_off(latch_off),
    .bias_en(bias_en), .standby(standby)
  );

  // reference model: mode 0 waiting, 1 conducting, 2 standby, 3 faulted, 4 locked
  int mode = 0;
  int ticks_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; ticks_seen = 0;
    end else if (mode == 4 || latch_off) begin
      mode = 4; ticks_seen = 0;
    end else if (fault_cfm) begin
      mode = 3; ticks_seen = 0;
    end else if (mode == 3) begin
      mode = 0;
    end else if (mode == 0) begin
      if (start_ok) mode = 1;
    end else if (mode == 2) begin
      if (fb_above_exit) mode = 1;
    end else begin
      if (!fb_below_skip || fb_above_exit) ticks_seen = 0;
      else if (tick_ms) begin
        ticks_seen++;
        if (ticks_seen == WIN) begin mode = 2; ticks_seen = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic eb, es;
      eb = (mode == 1);
      es = (mode == 2);
      vectors++;
      if (bias_en !== eb || standby !== es) begin
        miscompares++;
        $display("FAIL %s t=%0t bias_en=%b standby=%b expected bias_en=%b standby=%b",
                 cur_req, $time, bias_en, standby, eb, es);
      end
    end
  end

  task automatic cyc(input bit t);
    tick_ms = t;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0); cyc(0); cyc(0); cyc(1);
    end
    tick_ms = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1"; repeat (4) cyc(0);
    rst_n = 1'b1;
    cur_req = "R2"; ticks(3);              // no start_ok: stays open
    start_ok = 1; cyc(0); start_ok = 0; cyc(0);
    cur_req = "R4"; fb_below_skip = 1; ticks(60);
    fb_below_skip = 0; cyc(0);             // count cleared
    fb_below_skip = 1; ticks(WIN - 1);     // one short of a fresh window
    cur_req = "R3"; ticks(1); cyc(0);      // enters standby
    cur_req = "R6";
    for (int k = 0; k < 20; k++) begin fb_below_skip = k[0]; ticks(1); end
    cur_req = "R5"; fb_above_exit = 1; cyc(0); fb_above_exit = 0; cyc(0);
    cur_req = "R9"; fb_below_skip = 1; ticks(WIN - 1);
    cyc(0); cyc(0); cyc(0); fb_above_exit = 1; cyc(1); fb_above_exit = 0;
    ticks(WIN - 1); cyc(0);                // still conducting
    ticks(1); cyc(0);                      // now standby
    cur_req = "R9"; fb_above_exit = 1; fault_cfm = 1; cyc(0);
    fb_above_exit = 0;
    cur_req = "R7"; start_ok = 1; repeat (5) cyc(0);
    fault_cfm = 0; start_ok = 0; cyc(0); cyc(0);
    start_ok = 1; cyc(0); start_ok = 0; fb_below_skip = 0; cyc(0);
    fault_cfm = 1; ticks(2); fault_cfm = 0; cyc(0);
    start_ok = 1; cyc(0); start_ok = 0;
    cur_req = "R8"; latch_off = 1; cyc(0); latch_off = 0;
    start_ok = 1; fb_above_exit = 1; ticks(3);
    fb_above_exit = 0; fault_cfm = 1; cyc(0); fault_cfm = 0; ticks(2);
    cur_req = "R1"; rst_n = 0; cyc(0); cyc(0); start_ok = 0; rst_n = 1;
    cur_req = "R10"; start_ok = 1; cyc(0); start_ok = 0;
    fb_below_skip = 1; ticks(WIN + 2); fb_above_exit = 1; ticks(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule